// File: doc/BRIEF.md
# Dual Interrupt Pin Mapper

This block takes a small set of level-type status conditions and routes them onto two interrupt pins. Each pin owns a map register. The low bits of the map register choose which conditions drive the pin. The top bit chooses whether the pin is asserted high or low. A condition may drive one pin, both pins or neither pin. When several conditions drive the same pin, the pin's asserted state is the OR of those conditions.

For each pin the block delivers a data bit and an output-enable. A tri-state buffer at chip level uses the two to drive the pin or let it float. The pin floats during reset, and it also floats whenever its map register enables no condition at all. The pin outputs are registered, so a change on a status input appears on the pin one clock later.

The map registers are written through a per-pin write strobe and a shared data word. A write takes effect at the next clock edge. The status logic, the register bus decode and the host interrupt handling are outside this block.

Top module: `irq_pin_mapper`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises before any map is written, both `pin_oe` bits are 0 and both `pin_data` bits are 0, whatever the status inputs are.
- R2: Both map registers reset to 0. Pulsing `map_wr_en[p]` high at a rising edge loads `map_wr_data` into the map of pin `p` only. The other pin's map is unchanged.
- R3: One condition may be enabled on pin 0 alone, on pin 1 alone, on both or on neither. Each pin follows only its own map.
- R4: When a pin has several conditions enabled, its asserted state is the OR of those enabled conditions. A condition that is not enabled has no effect on that pin.
- R5: When a pin's enable field is all zero, its `pin_oe` is 0 and its `pin_data` is 0. Activity on the status inputs does not change either bit.
- R6: Map bit 7 selects polarity. With bit 7 at 0, an asserted pin has `pin_data` 1 and an idle pin has `pin_data` 0. With bit 7 at 1, both values are inverted. `pin_oe` is 1 whenever at least one condition is enabled.
- R7: `pin_data` and `pin_oe` are registered. They reflect the status inputs and the map as sampled at the preceding rising edge, which is one cycle of latency.
- R8: Map bit `i`, for `i` in 0..6, enables `status[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| status | input | 7 | Level status conditions, bit i is condition i |
| map_wr_en | input | 2 | Per-pin map write strobe, bit p selects pin p |
| map_wr_data | input | 8 | Map value: bit 7 selects active low, bits 6:0 are the condition enables |
| pin_data | output | 2 | Value to drive on each interrupt pin |
| pin_oe | output | 2 | Output-enable for each pin; 0 lets the pin float |

## Verification
The assertions assume that the status inputs are plain levels, stable around the clock edge. They compare each registered pin with the map and status values of the cycle before. For that reason they take no position on a write strobe and a status change landing in the same cycle. The bench drives every input on the falling edge, so each value is settled before the rising edge that samples it. After each random write and status pattern, it holds the inputs long enough for the map update and the output register to complete before it checks the pins.

// File: rtl/irq_pin_pkg.sv
// irq_pin_pkg
// Shared sizes and the polarity helper for the interrupt pin mapper.
// Assumes: a map word is one polarity bit above the condition enables.
package irq_pin_pkg;
    localparam int unsigned NUM_SRC_DEF = 7;
    localparam int unsigned NUM_PIN_DEF = 2;

    // Turn an asserted/idle level into the pin value for the chosen polarity.
    function automatic logic apply_polarity(input logic asserted, input logic act_low);
        return asserted ^ act_low;
    endfunction
endpackage

// File: rtl/irq_map_reg.sv
// irq_map_reg
// Holds one pin's map word: polarity select on top, condition enables below.
// Assumes: synchronous active-low reset, write strobe sampled on the rising edge.
module irq_map_reg #(
    parameter int unsigned NUM_SRC = 7,
    localparam int unsigned MAP_W  = NUM_SRC + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [MAP_W-1:0]   wr_data,
    output logic [NUM_SRC-1:0] src_en,
    output logic               act_low
);
    logic [MAP_W-1:0] map_q;

    // Load the map on a write strobe, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= '0;
        else if (wr_en)
            map_q <= wr_data;
    end

    // Split the stored word into its enable field and polarity bit.
    always_comb begin
        src_en  = map_q[NUM_SRC-1:0];
        act_low = map_q[MAP_W-1];
    end

    // R2: a write lands in the register at the next edge
    assert_map_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_q == $past(wr_data)));

    // R2: without a write the map holds
    assert_map_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(map_q));
endmodule

// File: rtl/irq_pin_drive.sv
// irq_pin_drive
// Combines the enabled status conditions for one pin, applies its polarity,
// and registers the pin value together with its output-enable.
// Assumes: status inputs are levels; enable and polarity come from a map register.
module irq_pin_drive
    import irq_pin_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               act_low,
    output logic               pin_data,
    output logic               pin_oe
);
    logic any_mapped;
    logic asserted;
    logic data_next;

    // OR of the enabled conditions and the enable decision for this pin.
    always_comb begin
        any_mapped = |src_en;
        asserted   = |(status & src_en);
        data_next  = any_mapped ? apply_polarity(asserted, act_low) : 1'b0;
    end

    // Register the pin value and its enable; float and drive 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_data <= 1'b0;
            pin_oe   <= 1'b0;
        end else begin
            pin_data <= data_next;
            pin_oe   <= any_mapped;
        end
    end

    // R1: a reset cycle leaves the pin floating and low
    assert_reset_float_R1: assert property (@(posedge clk)
        !rst_n |=> (!pin_oe && !pin_data));

    // R5: nothing enabled means the pin floats next cycle
    assert_unmapped_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |=> !pin_oe);

    // R5: a floating pin always carries 0
    assert_float_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_data);

    // R4 R6 R7: an enabled active condition gives the asserted level one cycle later
    assert_or_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & src_en) != '0) |=> (pin_oe && (pin_data == !$past(act_low))));

    // R6: mapped but idle gives the idle level for the chosen polarity
    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_en != '0) && ((status & src_en) == '0)) |=>
            (pin_oe && (pin_data == $past(act_low))));
endmodule

// File: rtl/irq_pin_mapper.sv
// irq_pin_mapper
// Top of the dual interrupt pin mapper: one map register and one pin driver
// per pin, built by a generate loop over the pin count.
// Assumes: the chip top puts a tri-state buffer on each pin_data/pin_oe pair.
module irq_pin_mapper
    import irq_pin_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF,
    parameter int unsigned NUM_PIN = NUM_PIN_DEF,
    localparam int unsigned MAP_W  = NUM_SRC + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_PIN-1:0] map_wr_en,
    input  logic [MAP_W-1:0]   map_wr_data,
    output logic [NUM_PIN-1:0] pin_data,
    output logic [NUM_PIN-1:0] pin_oe
);
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        logic [NUM_SRC-1:0] src_en;
        logic               act_low;

        irq_map_reg #(.NUM_SRC(NUM_SRC)) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (map_wr_en[p]),
            .wr_data (map_wr_data),
            .src_en  (src_en),
            .act_low (act_low)
        );

        irq_pin_drive #(.NUM_SRC(NUM_SRC)) u_drive (
            .clk      (clk),
            .rst_n    (rst_n),
            .status   (status),
            .src_en   (src_en),
            .act_low  (act_low),
            .pin_data (pin_data[p]),
            .pin_oe   (pin_oe[p])
        );
    end

    // R1: both pins float on the cycle after any reset cycle
    assert_both_float_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0));
endmodule

// File: tb/irq_pin_mapper_tb.sv
// irq_pin_mapper_tb
// Random writes and status patterns plus directed corners, checked against a bench model.
module irq_pin_mapper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] status = '0;
    logic [1:0] map_wr_en = '0;
    logic [7:0] map_wr_data = '0;
    logic [1:0] pin_data;
    logic [1:0] pin_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] mdl [2];

    irq_pin_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .status(status),
        .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
        .pin_data(pin_data), .pin_oe(pin_oe)
    );

    always #5 clk = ~clk;

    // Expected output-enable: any of bits 6:0 set (R5, R8)
    function automatic logic exp_oe(input logic [7:0] m);
        return |m[6:0];
    endfunction

    // Expected pin value: OR of enabled conditions, inverted by bit 7 (R4, R6)
    function automatic logic exp_data(input logic [7:0] m, input logic [6:0] s);
        if (m[6:0] == '0) return 1'b0;
        return (|(m[6:0] & s)) ^ m[7];
    endfunction

    task automatic check_pins(input string rq);
        for (int p = 0; p < 2; p++) begin
            logic eo, ed;
            eo = exp_oe(mdl[p]);
            ed = exp_data(mdl[p], status);
            checks++;
            if (pin_oe[p] !== eo || pin_data[p] !== ed) begin
                fails++;
                $display("FAIL %s pin%0d: oe=%b data=%b expected oe=%b data=%b (map=%h status=%b)",
                         rq, p, pin_oe[p], pin_data[p], eo, ed, mdl[p], status);
            end
        end
    endtask

    // Write a map at the next edge, then allow the output register to follow.
    task automatic write_map(input int p, input logic [7:0] v);
        map_wr_en   = 2'b01 << p;
        map_wr_data = v;
        @(negedge clk);
        map_wr_en = '0;
        mdl[p] = v;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        mdl[0] = '0;
        mdl[1] = '0;

        // R1: reset holds both pins floating even with writes and status active
        @(negedge clk);
        status = 7'h7F;
        map_wr_en = 2'b11;
        map_wr_data = 8'h7F;
        @(negedge clk);
        @(negedge clk);
        map_wr_en = '0;
        check_pins("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_pins("R1 after reset, R2 map reset zero");

        // R5: unmapped pins ignore status activity
        for (int i = 0; i < 6; i++) begin
            status = 7'($urandom);
            @(negedge clk);
            check_pins("R5 unmapped ignores status");
        end

        // R2 R8: pin 0 only, one bit per condition, active high
        for (int i = 0; i < 7; i++) begin
            write_map(0, 8'(1 << i));
            status = 7'(1 << i);
            @(negedge clk);
            check_pins("R8 bit i selects status i, R2 pin1 untouched");
            status = ~7'(1 << i);
            @(negedge clk);
            check_pins("R8 other conditions ignored");
        end

        // R3: one condition on pin1 alone, both, neither
        write_map(0, 8'h00);
        write_map(1, 8'h04);
        status = 7'h04;
        @(negedge clk);
        check_pins("R3 pin1 alone");
        write_map(0, 8'h04);
        @(negedge clk);
        check_pins("R3 both pins");
        write_map(0, 8'h00);
        write_map(1, 8'h00);
        check_pins("R3 neither pin");

        // R6: active low polarity, idle then asserted
        write_map(1, 8'h83);
        status = 7'h00;
        @(negedge clk);
        check_pins("R6 active low idle high");
        status = 7'h02;
        @(negedge clk);
        check_pins("R6 active low asserted");
        write_map(1, 8'h80);
        check_pins("R6 polarity only, R5 floats");

        // R7: one cycle latency on a status change with a fixed map
        write_map(0, 8'h10);
        status = 7'h00;
        @(negedge clk);
        status = 7'h10;
        #1;
        checks++;
        if (pin_data[0] !== 1'b0) begin
            fails++;
            $display("FAIL R7 before edge: data=%b expected 0", pin_data[0]);
        end
        @(negedge clk);
        checks++;
        if (pin_data[0] !== 1'b1) begin
            fails++;
            $display("FAIL R7 after one edge: data=%b expected 1", pin_data[0]);
        end

        // R4 and mixed: random maps and status patterns
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0)
                write_map(int'($urandom_range(0, 1)), 8'($urandom));
            status = 7'($urandom);
            @(negedge clk);
            check_pins("R4 random OR combine");
        end

        // R1: reset in mid-run floats both pins again
        write_map(0, 8'hFF);
        write_map(1, 8'h7F);
        rst_n = 1'b0;
        @(negedge clk);
        mdl[0] = '0;
        mdl[1] = '0;
        rst_n = 1'b1;
        status = 7'h7F;
        @(negedge clk);
        check_pins("R1 mid-run reset clears maps");

        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: done=0 expected 1");
            finish_run();
        end
    end
endmodule